// File: doc/BRIEF.md
# Buck Regulator Soft-Start and Protection Supervisor

This block is a synchronous digital supervisor for a two-phase buck regulator. It works on digitized samples of the output voltage. On leaving reset it ramps an internal reference from zero up to a programmed target code. It checks every accepted sample against three limits: a power-good window around the reference, a fixed absolute over-voltage limit, and an under-voltage limit that tracks the live ramp. It then drives per-phase switch permissions, an open-drain power-good pair and a fault flag.

Samples arrive on a valid/ready stream. `smp_ready` is held high at all times, so the block never applies back-pressure. A sample is consumed on every rising clock edge where `smp_valid` is high, and the producer may present a new sample on every cycle. Both voltage codes are 12-bit unsigned values at 1 mV per LSB.

The power-good pad is modelled as open drain. `pg_pull_low` enables the low driver, and `pg_pad_level` is the value that is driven, which is always 0. The pad reads high only through its external pull-up.

Top module: `vreg_supervisor`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: all four switch permissions are 0, `fault` is 0, `pg_pull_low` is 1 and `ramp_ref` is 0. `smp_ready` is always 1.
- R2: The first clock edge after reset release enters soft start with `ramp_ref`=0. After the k-th soft-start edge, `ramp_ref` = (target×k)>>11. After the 2048th soft-start edge the block is in normal run with `ramp_ref` equal to the target, and it then follows the target with one edge of delay.
- R3: `pg_pull_low` stays 1 for the whole soft start, whatever the samples are.
- R4: In normal run, each accepted sample sets `pg_pull_low` to 0 if lo ≤ sample ≤ hi, and to 1 otherwise. The bounds are computed from r = `ramp_ref` as lo = r−(r>>3)+(r>>8)+(r>>9) and hi = r+(r>>3)−(r>>8)−(r>>9).
- R5: In soft start or normal run, an accepted sample ≥ 1976 trips over-voltage on that edge. The outputs become high-side permissions 2'b00, low-side permissions 2'b11 and `fault`=1. A sample of 1975 does not trip.
- R6: Over-voltage is latched. Later samples of any value leave the outputs unchanged until `rst_n` is asserted.
- R7: Once under-voltage is armed, two consecutive accepted samples below u = (r>>1)+(r>>3)+(r>>4)+(r>>7)+(r>>8) switch everything off: all permissions are 0 and `fault`=1. This state is also latched until reset. A single low sample followed by one at or above u does not trip.
- R8: Under-voltage is armed by the first accepted sample ≥ 800 after reset. That arming sample never counts as a low sample.
- R9: During soft start, u is computed from the current ramp value and not from the target.
- R10: A sample that satisfies both the over-voltage and the under-voltage conditions leads to the over-voltage state.
- R11: A cycle with `smp_valid` low has no effect on protection or power good, whatever `vsense` holds.
- R12: In soft start and normal run, the high-side permissions are 2'b11 and the low-side permissions are 2'b00. In no state does a phase have both permissions set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-cycle) |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready, constant 1 |
| vsense | input | 12 | Sensed output voltage code, 1 mV/LSB |
| vtarget | input | 12 | Programmed reference code |
| hs_en | output | 2 | High-side switching permission, one bit per phase |
| ls_en | output | 2 | Low-side forced-on, one bit per phase |
| pg_pull_low | output | 1 | Power-good pull-down enable (1 = not good) |
| pg_pad_level | output | 1 | Level driven when pulling, constant 0 |
| fault | output | 1 | Protection fault flag |
| ramp_ref | output | 12 | Current internal reference |

## Verification
The state register drives every output one edge after the deciding sample. A wrong state therefore shows at the switch permissions and at `fault` by the next clock edge, as either a missed or a spurious trip. A ramp counter that is off by even one step shows in `ramp_ref` at the quarter and half points. It also shifts the entry into run by a cycle, which the edges just before and after the 2048th expose. Arming or low-sample bookkeeping that is stale shows only on the second low sample, so each case is driven as a sequence of two or three samples.

// File: rtl/vsup_pkg.sv
package vsup_pkg;
  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_OV    = 3'd3,
    ST_UV    = 3'd4
  } vsup_state_e;
endpackage

// File: rtl/vsup_ramp.sv
module vsup_ramp #(
  parameter int W       = 12,
  parameter int SS_LOG2 = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         soft_en,
  input  logic         follow_en,
  input  logic [W-1:0] target,
  output logic [W-1:0] ramp,
  output logic         last_step
);
  localparam int CW = SS_LOG2 + 1;
  localparam int PW = W + CW;

  logic [SS_LOG2-1:0] cnt_q;
  logic [CW-1:0]      step;
  logic [PW-1:0]      prod;

  assign step      = {1'b0, cnt_q} + CW'(1);
  assign prod      = PW'(target) * PW'(step);
  assign last_step = soft_en && (cnt_q == {SS_LOG2{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ramp  <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      ramp  <= '0;
    end else if (soft_en) begin
      cnt_q <= step[SS_LOG2-1:0];
      ramp  <= prod[SS_LOG2 +: W];
    end else if (follow_en) begin
      ramp  <= target;
    end
  end

  // R2: ramp never falls while soft start runs on a steady target
  p_ramp_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_en && !clr && $stable(target)) |=> (ramp >= $past(ramp)));
endmodule

// File: rtl/vsup_thresh.sv
module vsup_thresh #(
  parameter int W = 12
) (
  input  logic [W-1:0] ref_v,
  output logic [W:0]   pg_lo,
  output logic [W:0]   pg_hi,
  output logic [W:0]   uv_lim
);
  logic [W:0] r;
  assign r = {1'b0, ref_v};

  // approx 0.881 x, 1.119 x and 0.699 x by shift-and-add
  always_comb begin
    pg_lo  = r - (r >> 3) + (r >> 8) + (r >> 9);
    pg_hi  = r + (r >> 3) - (r >> 8) - (r >> 9);
    uv_lim = (r >> 1) + (r >> 3) + (r >> 4) + (r >> 7) + (r >> 8);
  end
endmodule

// File: rtl/vreg_supervisor.sv
module vreg_supervisor
  import vsup_pkg::*;
#(
  parameter int W        = 12,
  parameter int SS_LOG2  = 11,
  parameter int OV_CODE  = 1976,
  parameter int ARM_CODE = 800,
  parameter int PHASES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [W-1:0]      vsense,
  input  logic [W-1:0]      vtarget,
  output logic [PHASES-1:0] hs_en,
  output logic [PHASES-1:0] ls_en,
  output logic              pg_pull_low,
  output logic              pg_pad_level,
  output logic              fault,
  output logic [W-1:0]      ramp_ref
);
  localparam logic [W-1:0] OV_LIM  = OV_CODE[W-1:0];
  localparam logic [W-1:0] ARM_LIM = ARM_CODE[W-1:0];

  vsup_state_e state_q, state_d;
  logic armed_q, low_q;
  logic [W:0] pg_lo, pg_hi, uv_lim;
  logic ramp_done, ov_hit, uv_hit, below, in_win, active;

  assign smp_ready    = 1'b1;
  assign pg_pad_level = 1'b0;

  vsup_ramp #(.W(W), .SS_LOG2(SS_LOG2)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (state_q == ST_RESET),
    .soft_en   (state_q == ST_SOFT),
    .follow_en (state_q == ST_RUN),
    .target    (vtarget),
    .ramp      (ramp_ref),
    .last_step (ramp_done)
  );

  vsup_thresh #(.W(W)) u_thr (
    .ref_v  (ramp_ref),
    .pg_lo  (pg_lo),
    .pg_hi  (pg_hi),
    .uv_lim (uv_lim)
  );

  always_comb begin
    active = (state_q == ST_SOFT) || (state_q == ST_RUN);
    below  = {1'b0, vsense} < uv_lim;
    in_win = ({1'b0, vsense} >= pg_lo) && ({1'b0, vsense} <= pg_hi);
    ov_hit = active && smp_valid && (vsense >= OV_LIM);
    uv_hit = active && smp_valid && armed_q && low_q && below;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET: state_d = ST_SOFT;
      ST_SOFT: begin
        if (ov_hit)         state_d = ST_OV;
        else if (uv_hit)    state_d = ST_UV;
        else if (ramp_done) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (ov_hit)      state_d = ST_OV;
        else if (uv_hit) state_d = ST_UV;
      end
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RESET;
      armed_q     <= 1'b0;
      low_q       <= 1'b0;
      pg_pull_low <= 1'b1;
      hs_en       <= '0;
      ls_en       <= '0;
      fault       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (active && smp_valid) begin
        armed_q <= armed_q || (vsense >= ARM_LIM);
        low_q   <= armed_q && below;
      end
      if (state_d != ST_RUN)
        pg_pull_low <= 1'b1;
      else if (state_q == ST_RUN && smp_valid)
        pg_pull_low <= !in_win;
      unique case (state_d)
        ST_SOFT, ST_RUN: begin hs_en <= '1; ls_en <= '0; fault <= 1'b0; end
        ST_OV:           begin hs_en <= '0; ls_en <= '1; fault <= 1'b1; end
        ST_UV:           begin hs_en <= '0; ls_en <= '0; fault <= 1'b1; end
        default:         begin hs_en <= '0; ls_en <= '0; fault <= 1'b0; end
      endcase
    end
  end

  // R12: no phase has both switch permissions
  p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en & ls_en) == '0);
  // R3: power good is never released outside normal run
  p_pg_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |-> pg_pull_low);
  // R5: an over-limit sample in an active state trips on that edge
  p_ov_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && smp_valid && vsense >= OV_LIM) |=> (fault && ls_en == '1 && hs_en == '0));
  // R6: over-voltage is held
  p_ov_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OV) |=> (state_q == ST_OV && ls_en == '1));
  // R7: under-voltage off state is held
  p_uv_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UV) |=> (state_q == ST_UV && hs_en == '0 && ls_en == '0));
endmodule

// File: tb/vreg_supervisor_tb_top.sv
`timescale 1ns/1ps
module vreg_supervisor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [11:0] vsense = '0;
  logic [11:0] vtarget = '0;
  logic [1:0]  hs_en, ls_en;
  logic        pg_pull_low, pg_pad_level, fault;
  logic [11:0] ramp_ref;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  vreg_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .vsense(vsense), .vtarget(vtarget), .hs_en(hs_en), .ls_en(ls_en),
    .pg_pull_low(pg_pull_low), .pg_pad_level(pg_pad_level), .fault(fault),
    .ramp_ref(ramp_ref)
  );

  // {sample, expected pg_pull_low} for target 1000: lo=879 hi=1121 (R4)
  localparam int NTAB = 8;
  localparam logic [12:0] TAB [NTAB] = '{
    {12'd1000, 1'b0}, {12'd879, 1'b0}, {12'd878, 1'b1}, {12'd1121, 1'b0},
    {12'd1122, 1'b1}, {12'd950, 1'b0}, {12'd700, 1'b1}, {12'd1050, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [11:0] v);
    smp_valid = 1'b1;
    vsense = v;
    tick(1);
    smp_valid = 1'b0;
  endtask

  task automatic start(input logic [11:0] tgt);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    vtarget = tgt;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(2);
    // R1 reset state
    chk(hs_en == 0 && ls_en == 0 && fault == 0, "R1 switches/fault", {hs_en, ls_en, fault}, 0);
    chk(pg_pull_low == 1 && ramp_ref == 0 && smp_ready == 1, "R1 pg/ramp/ready",
        {pg_pull_low, smp_ready}, 3);

    // Test A: target 1000
    start(12'd1000);
    chk(ramp_ref == 0, "R2 ramp at entry", ramp_ref, 0);
    chk(hs_en == 2'b11 && ls_en == 2'b00, "R12 soft-start permissions", {hs_en, ls_en}, 12);
    tick(1024);
    chk(ramp_ref == 500, "R2 ramp half way", ramp_ref, 500);
    send(12'd1000);                     // arms UV; in window of target but soft start
    chk(pg_pull_low == 1, "R3 pg held in soft start", pg_pull_low, 1);
    send(12'd400);                      // below 0.7*1000, above 0.7*ramp
    send(12'd400);
    chk(fault == 0, "R9 uv uses ramp", fault, 0);
    tick(1020);                         // soft-start edge 2047
    chk(ramp_ref == 999 && pg_pull_low == 1, "R2/R3 before run", ramp_ref, 999);
    tick(1);
    chk(ramp_ref == 1000, "R2 ramp reaches target", ramp_ref, 1000);
    chk(hs_en == 2'b11 && ls_en == 2'b00, "R12 run permissions", {hs_en, ls_en}, 12);
    for (int i = 0; i < NTAB; i++) begin
      send(TAB[i][12:1]);
      chk(pg_pull_low == TAB[i][0], "R4 window", pg_pull_low, TAB[i][0]);
    end
    vsense = 12'd2000;
    tick(1);                            // valid low
    chk(fault == 0 && pg_pull_low == 0, "R11 invalid sample ignored", fault, 0);
    send(12'd600);
    send(12'd1000);
    chk(fault == 0, "R7 single low sample", fault, 0);
    send(12'd600);
    send(12'd600);
    chk(fault == 1 && hs_en == 0 && ls_en == 0, "R7 uv trip", {fault, hs_en, ls_en}, 16);
    send(12'd1000);
    chk(fault == 1 && hs_en == 0 && pg_pull_low == 1, "R7 uv held", {fault, hs_en}, 4);

    // Test B: over-voltage in soft start
    start(12'd1000);
    tick(10);
    send(12'd1975);
    chk(fault == 0 && hs_en == 2'b11, "R5 1975 no trip", fault, 0);
    send(12'd1976);
    chk(fault == 1 && hs_en == 2'b00 && ls_en == 2'b11, "R5 ov trip", {fault, hs_en, ls_en}, 19);
    send(12'd500);
    send(12'd500);
    send(12'd1000);
    tick(3000);
    chk(fault == 1 && ls_en == 2'b11 && hs_en == 0 && pg_pull_low == 1, "R6 ov latched",
        {fault, hs_en, ls_en}, 19);

    // Test C: arming and priority, target 3000 (u=2096)
    start(12'd3000);
    tick(2048);
    chk(ramp_ref == 3000, "R2 run target 3000", ramp_ref, 3000);
    send(12'd600);
    send(12'd600);
    chk(fault == 0, "R8 unarmed lows ignored", fault, 0);
    send(12'd800);
    send(12'd1000);
    chk(fault == 0, "R8 arming sample not low", fault, 0);
    send(12'd1990);
    chk(fault == 1 && ls_en == 2'b11 && hs_en == 0, "R10 ov over uv", {fault, hs_en, ls_en}, 19);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule